// File: doc/BRIEF.md
# Thread-Partitioned Non-Blocking Data Cache Controller

This block is the data cache for a processor pipeline that interleaves many hardware threads. Each thread owns a private slice of the cache storage, and within that slice the cache is direct-mapped, allocates a line on a write miss and holds stores in the line until the line is evicted. A lookup takes three pipeline steps: the request is registered, the tag, flags and data word are read for the line the address selects, and the tag is then compared and the answer is routed back. A hit returns the addressed 32-bit word, or merges the store bytes into the line.

A miss never holds up the pipeline. The controller answers "replay", and the thread issues the same instruction again later. The first miss of a thread raises one line-read command towards memory. Refill data arrives later on a 128-bit path as two beats per 32-byte line, tagged with the thread number. Refills for different threads may arrive in any order. If the line being replaced holds unwritten stores, its old contents leave on a 128-bit write-back path, one half per refill beat, in the cycle after each beat. Each tag entry keeps a parity bit that is checked on every lookup.

Top module: `thread_dcache`

## Requirements
- R1: After reset no response, memory command or write-back is signalled, and every line of every thread is invalid, so the first access to any address misses.
- R2: A request sampled with `reqValid` high in cycle n produces exactly one response with `respValid` high in cycle n+3 that carries the same thread number, and nothing in cycle n+2. Requests may be issued in back-to-back cycles.
- R3: Address bits [4:2] select the 32-bit word of a line. Bits [IDX_W+4:5] select the line inside the thread's slice. The bits above form the physical tag. A load hit returns that word on `respRdata`.
- R4: Every response has exactly one of `respHit` or `respReplay` set. A miss by a thread with no outstanding miss raises `memCmdValid` in the same cycle as its replay response, with that thread number and the line address (the request address with bits [4:0] cleared).
- R5: A thread has at most one outstanding miss. Any miss while it is outstanding, including an access to the line being refilled, is answered with replay and raises no memory command.
- R6: Each thread has its own slice, so the same address used by two threads names two separate lines. Misses of different threads are outstanding together and may be refilled in any order.
- R7: A refill is beat 0 (bits [127:0] = line bytes 0..15) followed by beat 1 (bytes 16..31). The line becomes valid with its new tag after beat 1, and the next access to it hits.
- R8: A store hit writes byte lane i of `reqWdata` (bits 8i+7:8i) into the addressed word only when `reqBe[i]` is 1, and marks the line dirty. Later loads return the merged word.
- R9: When a refill beat arrives for a line whose old contents are dirty, the next cycle shows `wbValid` with `wbBeat` equal to that beat number, the old line address on `wbAddr` and the old half-line on `wbData`. A clean victim produces no write-back.
- R10: A store miss is answered with replay and allocates the line. After the refill the replayed store hits and updates the line.
- R11: While a thread has a miss outstanding, its accesses to other resident lines still hit and return data.
- R12: A tag parity mismatch on a valid line is reported on `respParityErr` and forces a replay. Lines written by the cache itself never report a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqTid | input | TID_W | Requesting thread |
| reqAddr | input | ADDR_W | Physical byte address |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqWdata | input | 32 | Store data |
| reqBe | input | 4 | Store byte-lane enables |
| respValid | output | 1 | Response present |
| respTid | output | TID_W | Thread of the response |
| respHit | output | 1 | Access completed |
| respReplay | output | 1 | Instruction must be reissued |
| respParityErr | output | 1 | Tag parity mismatch seen |
| respRdata | output | 32 | Load data on a hit |
| memCmdValid | output | 1 | Line read command to memory |
| memCmdTid | output | TID_W | Thread that owns the command |
| memCmdAddr | output | ADDR_W | Line address to read |
| fillValid | input | 1 | Refill beat present |
| fillTid | input | TID_W | Thread the refill belongs to |
| fillBeat | input | 1 | Refill beat number |
| fillData | input | 128 | Refill half-line |
| wbValid | output | 1 | Victim write-back beat present |
| wbBeat | output | 1 | Write-back beat number |
| wbAddr | output | ADDR_W | Victim line address |
| wbData | output | 128 | Victim half-line |

## Verification
Loads and stores are applied to lines that are cold, resident, dirty and still in refill. The replies show whether hit and replay are told apart correctly, and whether a memory command is raised only for the first miss of a thread. Words from both refill beats, together with full-word and partial byte-enable stores, show that word selection and lane merging work, and that the refill halves are placed correctly. The same address is used by several threads and their refills are returned in an order different from the misses, which checks that the slices are separate and that completion order is free. Evicting a dirty line and a clean line tells a correct write-back, with old address and old data in the right beat, apart from a spurious one.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int LINE_BYTES = 32;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int BEAT_W     = 128;
  localparam int WORD_W     = 32;
  localparam int BE_W       = WORD_W / 8;
  localparam int WSEL_W     = $clog2(LINE_W / WORD_W);
  localparam int WORD_SH    = $clog2(WORD_W);
  localparam int BEAT_SH    = $clog2(BEAT_W);

  // Strobes from control to datapath, decided in the compare stage
  typedef struct packed {
    logic commitStore;  // store hit: merge bytes, mark dirty
    logic commitMiss;   // first miss of a thread: record line, drop valid
  } dpStrobe_t;
endpackage

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int LINES   = 8,
  parameter int ADDR_W  = 32,
  localparam int TID_W  = $clog2(THREADS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int SLOT_W = TID_W + IDX_W,
  localparam int SLOTS  = THREADS * LINES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  reqTid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStore,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  input  dpStrobe_t         strobe,
  input  logic              fillValid,
  input  logic [TID_W-1:0]  fillTid,
  input  logic              fillBeat,
  input  logic [BEAT_W-1:0] fillData,
  output logic [TID_W-1:0]  s2Tid,
  output logic              s2Store,
  output logic              s2Hit,
  output logic              s2ParErr,
  output logic              s2Stale,
  output logic [WORD_W-1:0] respRdata,
  output logic [ADDR_W-1:0] memCmdAddr,
  output logic              wbValid,
  output logic              wbBeat,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [BEAT_W-1:0] wbData
);
  // Line storage, one slot per (thread, index)
  logic [TAG_W-1:0]  tagArr  [SLOTS];
  logic [LINE_W-1:0] dataArr [SLOTS];
  logic [SLOTS-1:0]  validArr, dirtyArr, parArr;
  logic [IDX_W-1:0]  pendIdx [THREADS];
  logic [TAG_W-1:0]  pendTag [THREADS];

  // Stage 1: prepare address
  logic [TID_W-1:0]  s1Tid;
  logic [ADDR_W-1:0] s1Addr;
  logic              s1Store;
  logic [WORD_W-1:0] s1Wdata;
  logic [BE_W-1:0]   s1Be;

  // Stage 2: tag, flags and word read
  logic [ADDR_W-1:0] s2Addr;
  logic [WORD_W-1:0] s2Wdata, s2Word;
  logic [BE_W-1:0]   s2Be;
  logic [TAG_W-1:0]  s2TagQ;
  logic              s2ValidQ, s2ParQ;

  logic [SLOT_W-1:0] s1Slot, s2Slot, fillSlot;
  logic [WSEL_W-1:0] s1Wsel, s2Wsel;
  logic              unusedAddrLow;

  assign s1Slot   = {s1Tid, s1Addr[OFF_W +: IDX_W]};
  assign s2Slot   = {s2Tid, s2Addr[OFF_W +: IDX_W]};
  assign fillSlot = {fillTid, pendIdx[fillTid]};
  assign s1Wsel   = s1Addr[OFF_W-1 -: WSEL_W];
  assign s2Wsel   = s2Addr[OFF_W-1 -: WSEL_W];
  assign unusedAddrLow = ^{s1Addr[1:0], s2Addr[1:0]};

  always_ff @(posedge clk) begin
    s1Tid   <= reqTid;
    s1Addr  <= reqAddr;
    s1Store <= reqStore;
    s1Wdata <= reqWdata;
    s1Be    <= reqBe;
    s2Tid   <= s1Tid;
    s2Addr  <= s1Addr;
    s2Store <= s1Store;
    s2Wdata <= s1Wdata;
    s2Be    <= s1Be;
    s2TagQ  <= tagArr[s1Slot];
    s2ValidQ <= validArr[s1Slot];
    s2ParQ  <= parArr[s1Slot];
    s2Word  <= dataArr[s1Slot][{s1Wsel, {WORD_SH{1'b0}}} +: WORD_W];
    // The slot read this edge is rewritten this edge: answer replay later
    s2Stale <= ((strobe.commitStore || strobe.commitMiss) && s2Slot == s1Slot)
            || (fillValid && fillSlot == s1Slot);
    respRdata <= s2Word;
  end

  // Stage 3: compare
  assign s2ParErr = s2ValidQ && ((^s2TagQ) != s2ParQ);
  assign s2Hit    = s2ValidQ && !s2ParErr && (s2TagQ == s2Addr[ADDR_W-1 -: TAG_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
    end else begin
      if (strobe.commitStore) dirtyArr[s2Slot] <= 1'b1;
      if (strobe.commitMiss)  validArr[s2Slot] <= 1'b0;
      if (fillValid && fillBeat) begin
        validArr[fillSlot] <= 1'b1;
        dirtyArr[fillSlot] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commitStore) begin
      for (int b = 0; b < BE_W; b++) begin
        if (s2Be[b])
          dataArr[s2Slot][{s2Wsel, 2'(b), 3'b000} +: 8] <= s2Wdata[b*8 +: 8];
      end
    end
    if (fillValid) begin
      dataArr[fillSlot][{fillBeat, {BEAT_SH{1'b0}}} +: BEAT_W] <= fillData;
      if (fillBeat) begin
        tagArr[fillSlot] <= pendTag[fillTid];
        parArr[fillSlot] <= ^pendTag[fillTid];
      end
    end
    if (strobe.commitMiss) begin
      pendIdx[s2Tid] <= s2Addr[OFF_W +: IDX_W];
      pendTag[s2Tid] <= s2Addr[ADDR_W-1 -: TAG_W];
      memCmdAddr     <= {s2Addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  // Victim half leaves in the cycle after the refill beat that replaces it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
    end else begin
      wbValid <= fillValid && dirtyArr[fillSlot];
    end
    wbBeat <= fillBeat;
    wbData <= dataArr[fillSlot][{fillBeat, {BEAT_SH{1'b0}}} +: BEAT_W];
    wbAddr <= {tagArr[fillSlot], pendIdx[fillTid], {OFF_W{1'b0}}};
  end

  assert_store_sets_dirty_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitStore |=> dirtyArr[$past(s2Slot)]);

  assert_refill_validates_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillBeat) |=> validArr[$past(fillSlot)]);

  assert_wb_follows_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(fillValid));
endmodule

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
#(
  parameter int THREADS = 4,
  localparam int TID_W  = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [TID_W-1:0] s2Tid,
  input  logic             s2Store,
  input  logic             s2Hit,
  input  logic             s2ParErr,
  input  logic             s2Stale,
  input  logic             fillValid,
  input  logic [TID_W-1:0] fillTid,
  input  logic             fillBeat,
  output dpStrobe_t        strobe,
  output logic             respValid,
  output logic [TID_W-1:0] respTid,
  output logic             respHit,
  output logic             respReplay,
  output logic             respParityErr,
  output logic             memCmdValid,
  output logic [TID_W-1:0] memCmdTid
);
  logic               v1, v2, lookHit;
  logic [THREADS-1:0] pendValid;

  assign lookHit            = v2 && s2Hit && !s2Stale;
  assign strobe.commitStore = lookHit && s2Store;
  assign strobe.commitMiss  = v2 && !s2Hit && !s2Stale && !pendValid[s2Tid];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1            <= 1'b0;
      v2            <= 1'b0;
      pendValid     <= '0;
      respValid     <= 1'b0;
      respHit       <= 1'b0;
      respReplay    <= 1'b0;
      respParityErr <= 1'b0;
      memCmdValid   <= 1'b0;
    end else begin
      v1            <= reqValid;
      v2            <= v1;
      respValid     <= v2;
      respHit       <= lookHit;
      respReplay    <= v2 && !lookHit;
      respParityErr <= v2 && s2ParErr;
      memCmdValid   <= strobe.commitMiss;
      if (strobe.commitMiss)      pendValid[s2Tid]   <= 1'b1;
      if (fillValid && fillBeat)  pendValid[fillTid] <= 1'b0;
    end
    respTid   <= s2Tid;
    memCmdTid <= s2Tid;
  end

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ##3 respValid);

  assert_hit_xor_replay_R4: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respHit != respReplay));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respReplay || memCmdValid));

  assert_cmd_with_replay_R4: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |-> (respReplay && respTid == memCmdTid));

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |=> !(memCmdValid && memCmdTid == $past(memCmdTid)));
endmodule

// File: rtl/thread_dcache.sv
module thread_dcache
  import tdc_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int LINES   = 8,
  parameter int ADDR_W  = 32,
  localparam int TID_W  = $clog2(THREADS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TID_W-1:0]  reqTid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStore,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqBe,
  output logic              respValid,
  output logic [TID_W-1:0]  respTid,
  output logic              respHit,
  output logic              respReplay,
  output logic              respParityErr,
  output logic [31:0]       respRdata,
  output logic              memCmdValid,
  output logic [TID_W-1:0]  memCmdTid,
  output logic [ADDR_W-1:0] memCmdAddr,
  input  logic              fillValid,
  input  logic [TID_W-1:0]  fillTid,
  input  logic              fillBeat,
  input  logic [127:0]      fillData,
  output logic              wbValid,
  output logic              wbBeat,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [127:0]      wbData
);
  dpStrobe_t        strobe;
  logic [TID_W-1:0] s2Tid;
  logic             s2Store, s2Hit, s2ParErr, s2Stale;

  tdc_datapath #(.THREADS(THREADS), .LINES(LINES), .ADDR_W(ADDR_W)) datapath_i (
    .clk, .rstN, .reqTid, .reqAddr, .reqStore, .reqWdata, .reqBe, .strobe,
    .fillValid, .fillTid, .fillBeat, .fillData,
    .s2Tid, .s2Store, .s2Hit, .s2ParErr, .s2Stale,
    .respRdata, .memCmdAddr, .wbValid, .wbBeat, .wbAddr, .wbData
  );

  tdc_control #(.THREADS(THREADS)) control_i (
    .clk, .rstN, .reqValid, .s2Tid, .s2Store, .s2Hit, .s2ParErr, .s2Stale,
    .fillValid, .fillTid, .fillBeat, .strobe,
    .respValid, .respTid, .respHit, .respReplay, .respParityErr,
    .memCmdValid, .memCmdTid
  );
endmodule

// File: tb/thread_dcache_tb_top.sv
module thread_dcache_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid, reqStore;
  logic [1:0]   reqTid;
  logic [31:0]  reqAddr, reqWdata;
  logic [3:0]   reqBe;
  logic         respValid, respHit, respReplay, respParityErr;
  logic [1:0]   respTid;
  logic [31:0]  respRdata;
  logic         memCmdValid;
  logic [1:0]   memCmdTid;
  logic [31:0]  memCmdAddr;
  logic         fillValid, fillBeat;
  logic [1:0]   fillTid;
  logic [127:0] fillData;
  logic         wbValid, wbBeat;
  logic [31:0]  wbAddr;
  logic [127:0] wbData;

  always #5 clk = ~clk;

  thread_dcache #(.THREADS(4), .LINES(8), .ADDR_W(32)) dut_i (.*);

  int vecCount = 0;
  int missCount = 0;

  // Captured results
  logic         rValid, rHit, rReplay, rPar, rIssue, rEarly;
  logic [1:0]   rTid, rCmdTid;
  logic [31:0]  rData, rCmdAddr;
  logic [31:0]  cmdLine [4];
  logic         wbV [2];
  logic         wbB [2];
  logic [31:0]  wbA [2];
  logic [127:0] wbD [2];

  typedef struct packed {
    logic [1:0]  tid;
    logic [31:0] addr;
    logic        st;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        expHit;
    logic        expIssue;
    logic        doFill;
    logic [1:0]  expKind;  // 0 none, 1 refill pattern, 2 pattern merged with wdata/be
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 32'h0000_1040, 1'b0, 32'h0,         4'h0, 1'b0, 1'b1, 1'b1, 2'd0}, // R4 cold miss
    '{2'd0, 32'h0000_1044, 1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 2'd1}, // R3 R7 beat 0 word
    '{2'd0, 32'h0000_105C, 1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 2'd1}, // R7 beat 1 word
    '{2'd0, 32'h0000_1048, 1'b1, 32'h1122_3344, 4'h5, 1'b1, 1'b0, 1'b0, 2'd0}, // R8 partial store
    '{2'd0, 32'h0000_1048, 1'b0, 32'h1122_3344, 4'h5, 1'b1, 1'b0, 1'b0, 2'd2}, // R8 merged read
    '{2'd1, 32'h0000_1040, 1'b0, 32'h0,         4'h0, 1'b0, 1'b1, 1'b1, 2'd0}, // R6 other slice misses
    '{2'd1, 32'h0000_1048, 1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 2'd1}, // R6 unmerged copy
    '{2'd2, 32'h0000_3000, 1'b1, 32'hCAFE_F00D, 4'hF, 1'b0, 1'b1, 1'b1, 2'd0}, // R10 store miss
    '{2'd2, 32'h0000_3000, 1'b1, 32'hCAFE_F00D, 4'hF, 1'b1, 1'b0, 1'b0, 2'd0}, // R10 replayed store
    '{2'd2, 32'h0000_3000, 1'b0, 32'hCAFE_F00D, 4'hF, 1'b1, 1'b0, 1'b0, 2'd2}, // R10 stored value
    '{2'd3, 32'h00FF_FFE0, 1'b0, 32'h0,         4'h0, 1'b0, 1'b1, 1'b1, 2'd0}, // R3 top index
    '{2'd3, 32'h00FF_FFFC, 1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 2'd1}  // R3 last word
  };

  function automatic logic [31:0] patt(input logic [1:0] t, input logic [31:0] a);
    return a ^ {t, 30'h0} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] mergeWord(input logic [31:0] base, input logic [31:0] d,
                                            input logic [3:0] be);
    logic [31:0] m = base;
    for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = d[b*8 +: 8];
    return m;
  endfunction

  function automatic logic [127:0] beatData(input logic [1:0] t, input logic [31:0] line,
                                            input logic beat);
    logic [127:0] d;
    for (int w = 0; w < 4; w++) d[w*32 +: 32] = patt(t, line + 32'(beat ? 16 : 0) + 32'(4 * w));
    return d;
  endfunction

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] t, input logic [31:0] a, input logic s,
                        input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reqValid = 1'b1; reqTid = t; reqAddr = a; reqStore = s; reqWdata = d; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rEarly = respValid;
    @(negedge clk);
    rValid = respValid; rTid = respTid; rHit = respHit; rReplay = respReplay;
    rPar = respParityErr; rData = respRdata; rIssue = memCmdValid;
    rCmdTid = memCmdTid; rCmdAddr = memCmdAddr;
    if (memCmdValid) cmdLine[memCmdTid] = memCmdAddr;
  endtask

  task automatic fill(input logic [1:0] t);
    @(negedge clk);
    fillValid = 1'b1; fillTid = t; fillBeat = 1'b0; fillData = beatData(t, cmdLine[t], 1'b0);
    @(negedge clk);
    wbV[0] = wbValid; wbB[0] = wbBeat; wbA[0] = wbAddr; wbD[0] = wbData;
    fillBeat = 1'b1; fillData = beatData(t, cmdLine[t], 1'b1);
    @(negedge clk);
    wbV[1] = wbValid; wbB[1] = wbBeat; wbA[1] = wbAddr; wbD[1] = wbData;
    fillValid = 1'b0;
  endtask

  task automatic expectHit(input logic [1:0] t, input logic [31:0] a, input logic [31:0] exp,
                           input string what);
    access(t, a, 1'b0, 32'h0, 4'h0);
    chk({what, " hit"}, 128'(rHit), 128'(1));
    chk({what, " data"}, 128'(rData), 128'(exp));
  endtask

  task automatic expectReplay(input logic [1:0] t, input logic [31:0] a, input logic issue,
                              input string what);
    access(t, a, 1'b0, 32'h0, 4'h0);
    chk({what, " replay"}, 128'(rReplay), 128'(1));
    chk({what, " memCmd"}, 128'(rIssue), 128'(issue));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vecCount, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqTid = '0; reqAddr = '0; reqStore = 1'b0;
    reqWdata = '0; reqBe = '0; fillValid = 1'b0; fillTid = '0; fillBeat = 1'b0; fillData = '0;
    for (int i = 0; i < 4; i++) cmdLine[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 respValid idle", 128'(respValid), 128'(0));
    chk("R1 memCmdValid idle", 128'(memCmdValid), 128'(0));
    chk("R1 wbValid idle", 128'(wbValid), 128'(0));

    // Table walk
    for (int i = 0; i < 12; i++) begin
      access(VECS[i].tid, VECS[i].addr, VECS[i].st, VECS[i].wdata, VECS[i].be);
      chk($sformatf("R2 no early response v%0d", i), 128'(rEarly), 128'(0));
      chk($sformatf("R2 respValid v%0d", i), 128'(rValid), 128'(1));
      chk($sformatf("R2 respTid v%0d", i), 128'(rTid), 128'(VECS[i].tid));
      chk($sformatf("R4 hit v%0d", i), 128'(rHit), 128'(VECS[i].expHit));
      chk($sformatf("R4 replay v%0d", i), 128'(rReplay), 128'(!VECS[i].expHit));
      chk($sformatf("R4 memCmd v%0d", i), 128'(rIssue), 128'(VECS[i].expIssue));
      chk($sformatf("R12 parity v%0d", i), 128'(rPar), 128'(0));
      if (VECS[i].expIssue) begin
        chk($sformatf("R4 cmd line v%0d", i), 128'(rCmdAddr), 128'({VECS[i].addr[31:5], 5'b0}));
        chk($sformatf("R4 cmd tid v%0d", i), 128'(rCmdTid), 128'(VECS[i].tid));
      end
      if (VECS[i].expKind == 2'd1)
        chk($sformatf("R3 data v%0d", i), 128'(rData), 128'(patt(VECS[i].tid, VECS[i].addr)));
      if (VECS[i].expKind == 2'd2)
        chk($sformatf("R8 merged data v%0d", i), 128'(rData),
            128'(mergeWord(patt(VECS[i].tid, VECS[i].addr), VECS[i].wdata, VECS[i].be)));
      if (VECS[i].doFill) fill(VECS[i].tid);
    end

    // R9: dirty victim leaves with old address and old halves
    expectReplay(2'd0, 32'h0000_2040, 1'b1, "R9 dirty victim miss");
    chk("R4 cmd line conflict", 128'(rCmdAddr), 128'(32'h0000_2040));
    fill(2'd0);
    chk("R9 wb beat0 valid", 128'(wbV[0]), 128'(1));
    chk("R9 wb beat0 number", 128'(wbB[0]), 128'(0));
    chk("R9 wb beat0 addr", 128'(wbA[0]), 128'(32'h0000_1040));
    chk("R9 wb beat0 merged word", 128'(wbD[0][95:64]),
        128'(mergeWord(patt(2'd0, 32'h1048), 32'h1122_3344, 4'h5)));
    chk("R9 wb beat0 word0", 128'(wbD[0][31:0]), 128'(patt(2'd0, 32'h1040)));
    chk("R9 wb beat1 valid", 128'(wbV[1]), 128'(1));
    chk("R9 wb beat1 number", 128'(wbB[1]), 128'(1));
    chk("R9 wb beat1 addr", 128'(wbA[1]), 128'(32'h0000_1040));
    chk("R9 wb beat1 word7", 128'(wbD[1][127:96]), 128'(patt(2'd0, 32'h105C)));
    expectHit(2'd0, 32'h0000_2040, patt(2'd0, 32'h2040), "R7 new line");

    // R9: clean victim produces no write-back
    expectReplay(2'd1, 32'h0000_2040, 1'b1, "R9 clean victim miss");
    fill(2'd1);
    chk("R9 clean beat0 no wb", 128'(wbV[0]), 128'(0));
    chk("R9 clean beat1 no wb", 128'(wbV[1]), 128'(0));

    // R5 / R11: one outstanding miss per thread, hits continue meanwhile
    expectReplay(2'd3, 32'h0000_0000, 1'b1, "R5 first miss");
    expectReplay(2'd3, 32'h0000_0000, 1'b0, "R5 line in refill");
    expectReplay(2'd3, 32'h0000_0020, 1'b0, "R5 second line");
    expectHit(2'd3, 32'h00FF_FFE4, patt(2'd3, 32'h00FF_FFE4), "R11 hit under miss");

    // R6: misses from several threads, refilled in another order
    expectReplay(2'd1, 32'h0000_4060, 1'b1, "R6 t1 miss");
    expectReplay(2'd2, 32'h0000_4060, 1'b1, "R6 t2 miss");
    fill(2'd3);
    fill(2'd2);
    fill(2'd1);
    expectHit(2'd1, 32'h0000_4064, patt(2'd1, 32'h4064), "R6 t1 late refill");
    expectHit(2'd2, 32'h0000_4060, patt(2'd2, 32'h4060), "R6 t2 refill");
    expectHit(2'd3, 32'h0000_0000, patt(2'd3, 32'h0000), "R6 t3 first refill");

    // R8: single top byte lane
    access(2'd1, 32'h0000_4064, 1'b1, 32'hAB00_0000, 4'h8);
    chk("R8 byte store hit", 128'(rHit), 128'(1));
    expectHit(2'd1, 32'h0000_4064, mergeWord(patt(2'd1, 32'h4064), 32'hAB00_0000, 4'h8),
              "R8 top lane");

    // R2: back-to-back requests answered in consecutive cycles
    @(negedge clk);
    reqValid = 1'b1; reqTid = 2'd0; reqAddr = 32'h0000_2044; reqStore = 1'b0;
    @(negedge clk);
    reqTid = 2'd2; reqAddr = 32'h0000_4068;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R2 back-to-back first hit", 128'(respHit), 128'(1));
    chk("R2 back-to-back first data", 128'(respRdata), 128'(patt(2'd0, 32'h2044)));
    @(negedge clk);
    chk("R2 back-to-back second tid", 128'(respTid), 128'(2));
    chk("R2 back-to-back second data", 128'(respRdata), 128'(patt(2'd2, 32'h4068)));
    @(negedge clk);
    chk("R2 back-to-back done", 128'(respValid), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule